// File: doc/BRIEF.md
# Rotated Tiled-View Address Generator

This block turns a pixel coordinate inside a tiled frame-buffer container into the 32-bit address of that pixel as seen through one of eight rotated or mirrored views. Each request carries a two-bit tiling format, a three-bit view code and an (x, y) coordinate. The block works out how many coordinate bits the format allows and rejects coordinates outside that extent. It then mirrors and/or swaps the axes as the view requires, packs the pair into a linear offset and scales the offset by the pixel size. The view and format codes are placed in the top five address bits.

Beside the address, the block reports the line stride that a consumer must step by to move one line down in the chosen view. The stride depends on the format and on whether the view swaps the axes. Results are registered and appear one clock after the request, marked by a valid strobe. Memory access and the page translation that follows are handled elsewhere.

Top module: `tva_addr_gen`

## Requirements
- R1: Address bits [28:27] carry the request's format code: 0 for 8-bit tiles, 1 for 16-bit, 2 for 32-bit and 3 for page mode.
- R2: Address bits [31:29] carry the request's view code. View bit 0 mirrors X, view bit 1 mirrors Y and view bit 2 swaps the axes (0 = upright, 3 = half turn, 5 and 6 = quarter turns, 1/2/4/7 = the mirrored variants).
- R3: The format sets an X shift and a Y shift: (0,0) for 8-bit, (0,1) for 16-bit, (1,1) for 32-bit and (6,6) by default for page mode. The usable X width is CW_BITS minus the X shift and the usable Y width is CH_BITS minus the Y shift (defaults 14 and 13).
- R4: A coordinate with any bit set above its usable width gives an address of all zeros; the stride is still reported.
- R5: With view bit 0 set, x is replaced by x XOR the X mask; with view bit 1 set, y is replaced by y XOR the Y mask.
- R6: Without the swap bit the offset is (y << X width) + x; with it the offset is (x << Y width) + y.
- R7: The offset is shifted left by X shift plus Y shift before the code fields are merged into bits [31:27].
- R8: The stride is 1 << (CH_BITS + X shift) when the swap bit is set and 1 << (CW_BITS + Y shift) otherwise.
- R9: A request accepted on one clock edge produces its address, stride and a high out_valid after that edge; out_valid is low after any edge without a request.
- R10: Without a request, out_addr and out_stride keep their previous values.
- R11: While rst is high, out_valid, out_addr and out_stride are all zero after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_fmt | input | 2 | Tiling format code |
| in_view | input | 3 | View (rotation/mirror) code |
| in_x | input | COORD_W | Pixel column |
| in_y | input | COORD_W | Pixel row |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_addr | output | 32 | View address, zero when out of range |
| out_stride | output | 32 | Line stride for the view |

## Verification
A wrong format-to-shift decode shows up at once as a misplaced offset, a wrong stride power, or a false out-of-range zero on the first request of that format. A wrong mirror or swap moves the offset bits for every request with that view bit set, so the vector walk covers each view bit alone and combined across all four formats. Boundary requests at the exact mask limit and one past it separate a mask that is one bit too wide or too narrow. Because the stage is a single register, every such fault is visible on the cycle right after the faulting request, and the hold test exposes a register that loads without a strobe.

// File: rtl/tva_pkg.sv
package tva_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned FIELD_LO = 27;
  localparam int unsigned SH_W     = 5;
  localparam int unsigned NB_W     = 6;

  typedef enum logic [1:0] {
    FMT_TILE8  = 2'd0,
    FMT_TILE16 = 2'd1,
    FMT_TILE32 = 2'd2,
    FMT_PAGED  = 2'd3
  } tile_fmt_e;

  typedef struct packed {
    logic [SH_W-1:0] xsh;
    logic [SH_W-1:0] ysh;
  } fmt_shift_t;

  localparam int unsigned VB_XMIR = 0;
  localparam int unsigned VB_YMIR = 1;
  localparam int unsigned VB_SWAP = 2;
endpackage

// File: rtl/tva_geom.sv
module tva_geom
  import tva_pkg::*;
#(
  parameter int unsigned CW_BITS  = 14,
  parameter int unsigned CH_BITS  = 13,
  parameter int unsigned COORD_W  = 16,
  parameter int unsigned PG_XSH   = 6,
  parameter int unsigned PG_YSH   = 6
) (
  input  logic [1:0]         fmt,
  output logic [SH_W-1:0]    xsh,
  output logic [SH_W-1:0]    ysh,
  output logic [NB_W-1:0]    xbits,
  output logic [NB_W-1:0]    ybits,
  output logic [COORD_W-1:0] xmask,
  output logic [COORD_W-1:0] ymask
);
  fmt_shift_t sel;
  logic [31:0] xm_w, ym_w;

  always_comb begin
    unique case (tile_fmt_e'(fmt))
      FMT_TILE8:  sel = '{xsh: SH_W'(0), ysh: SH_W'(0)};
      FMT_TILE16: sel = '{xsh: SH_W'(0), ysh: SH_W'(1)};
      FMT_TILE32: sel = '{xsh: SH_W'(1), ysh: SH_W'(1)};
      default:    sel = '{xsh: SH_W'(PG_XSH), ysh: SH_W'(PG_YSH)};
    endcase
  end

  assign xsh   = sel.xsh;
  assign ysh   = sel.ysh;
  assign xbits = NB_W'(CW_BITS) - NB_W'(sel.xsh);
  assign ybits = NB_W'(CH_BITS) - NB_W'(sel.ysh);
  assign xm_w  = (32'd1 << xbits) - 32'd1;
  assign ym_w  = (32'd1 << ybits) - 32'd1;
  assign xmask = xm_w[COORD_W-1:0];
  assign ymask = ym_w[COORD_W-1:0];
endmodule

// File: rtl/tva_xform.sv
module tva_xform
  import tva_pkg::*;
#(
  parameter int unsigned COORD_W = 16
) (
  input  logic [1:0]          fmt,
  input  logic [2:0]          view,
  input  logic [COORD_W-1:0]  x,
  input  logic [COORD_W-1:0]  y,
  input  logic [SH_W-1:0]     xsh,
  input  logic [SH_W-1:0]     ysh,
  input  logic [NB_W-1:0]     xbits,
  input  logic [NB_W-1:0]     ybits,
  input  logic [COORD_W-1:0]  xmask,
  input  logic [COORD_W-1:0]  ymask,
  output logic [ADDR_W-1:0]   addr
);
  localparam int unsigned PAD_W = ADDR_W - COORD_W;

  logic               in_range;
  logic [COORD_W-1:0] xv, yv;
  logic [ADDR_W-1:0]  xw, yw, lin, scaled;
  logic [NB_W-1:0]    align;

  assign in_range = ((x & ~xmask) == '0) && ((y & ~ymask) == '0);

  assign xv = view[VB_XMIR] ? (x ^ xmask) : x;
  assign yv = view[VB_YMIR] ? (y ^ ymask) : y;

  assign xw = {{PAD_W{1'b0}}, xv};
  assign yw = {{PAD_W{1'b0}}, yv};

  assign lin    = view[VB_SWAP] ? ((xw << ybits) + yw) : ((yw << xbits) + xw);
  assign align  = NB_W'(xsh) + NB_W'(ysh);
  assign scaled = lin << align;

  assign addr = in_range ? {view, fmt, scaled[FIELD_LO-1:0]} : '0;
endmodule

// File: rtl/tva_stride.sv
module tva_stride
  import tva_pkg::*;
#(
  parameter int unsigned CW_BITS = 14,
  parameter int unsigned CH_BITS = 13
) (
  input  logic              swap,
  input  logic [SH_W-1:0]   xsh,
  input  logic [SH_W-1:0]   ysh,
  output logic [ADDR_W-1:0] stride
);
  logic [NB_W-1:0] pw;
  assign pw     = swap ? (NB_W'(CH_BITS) + NB_W'(xsh)) : (NB_W'(CW_BITS) + NB_W'(ysh));
  assign stride = ADDR_W'(1) << pw;
endmodule

// File: rtl/tva_addr_gen.sv
module tva_addr_gen
  import tva_pkg::*;
#(
  parameter int unsigned CW_BITS = 14,
  parameter int unsigned CH_BITS = 13,
  parameter int unsigned COORD_W = 16,
  parameter int unsigned PG_XSH  = 6,
  parameter int unsigned PG_YSH  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [1:0]         in_fmt,
  input  logic [2:0]         in_view,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  output logic               out_valid,
  output logic [31:0]        out_addr,
  output logic [31:0]        out_stride
);
  logic [SH_W-1:0]    g_xsh, g_ysh;
  logic [NB_W-1:0]    g_xbits, g_ybits;
  logic [COORD_W-1:0] g_xmask, g_ymask;
  logic [ADDR_W-1:0]  nxt_addr, nxt_stride;

  tva_geom #(
    .CW_BITS(CW_BITS), .CH_BITS(CH_BITS), .COORD_W(COORD_W),
    .PG_XSH(PG_XSH), .PG_YSH(PG_YSH)
  ) geom_i (
    .fmt(in_fmt), .xsh(g_xsh), .ysh(g_ysh),
    .xbits(g_xbits), .ybits(g_ybits),
    .xmask(g_xmask), .ymask(g_ymask)
  );

  tva_xform #(.COORD_W(COORD_W)) xform_i (
    .fmt(in_fmt), .view(in_view), .x(in_x), .y(in_y),
    .xsh(g_xsh), .ysh(g_ysh), .xbits(g_xbits), .ybits(g_ybits),
    .xmask(g_xmask), .ymask(g_ymask), .addr(nxt_addr)
  );

  tva_stride #(.CW_BITS(CW_BITS), .CH_BITS(CH_BITS)) stride_i (
    .swap(in_view[VB_SWAP]), .xsh(g_xsh), .ysh(g_ysh), .stride(nxt_stride)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_addr   <= '0;
      out_stride <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr   <= nxt_addr;
        out_stride <= nxt_stride;
      end
    end
  end
endmodule

// File: rtl/tva_addr_gen_chk.sv
module tva_addr_gen_chk #(
  parameter int unsigned CW_BITS = 14,
  parameter int unsigned COORD_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [1:0]         in_fmt,
  input logic [2:0]         in_view,
  input logic [COORD_W-1:0] in_x,
  input logic               out_valid,
  input logic [31:0]        out_addr,
  input logic [31:0]        out_stride
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && out_addr == 32'd0 && out_stride == 32'd0)); // R11

  AST_VALID_TRACK: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R9

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_addr) && $stable(out_stride))); // R10

  AST_FMT_FIELD: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_addr == 32'd0 || out_addr[28:27] == $past(in_fmt))); // R1

  AST_VIEW_FIELD: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_addr == 32'd0 || out_addr[31:29] == $past(in_view))); // R2

  AST_STRIDE_POW2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(out_stride) == 1)); // R8

  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ((in_x >> CW_BITS) != '0)) |=> (out_addr == 32'd0)); // R4

  AST_ALIGN32: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_fmt == 2'd2) |=> (out_addr[1:0] == 2'b00)); // R7
endmodule

bind tva_addr_gen tva_addr_gen_chk #(.CW_BITS(CW_BITS), .COORD_W(COORD_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_fmt(in_fmt), .in_view(in_view),
  .in_x(in_x), .out_valid(out_valid), .out_addr(out_addr), .out_stride(out_stride)
);

// File: tb/tva_addr_gen_tb_top.sv
`timescale 1ns/1ps
module tva_addr_gen_tb_top;
  localparam int NV = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_fmt = '0;
  logic [2:0]  in_view = '0;
  logic [15:0] in_x = '0;
  logic [15:0] in_y = '0;
  logic        out_valid;
  logic [31:0] out_addr, out_stride;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  tva_addr_gen dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_fmt(in_fmt), .in_view(in_view),
    .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .out_addr(out_addr),
    .out_stride(out_stride)
  );

  // Expected values worked out from R3..R8 with widths 14/13 and page shifts 6/6.
  localparam logic [1:0]  V_FMT  [NV] = '{0, 1, 2, 3, 0, 0, 2, 1, 3, 3, 2, 0, 1, 1};
  localparam logic [2:0]  V_VIEW [NV] = '{0, 0, 0, 0, 3, 4, 5, 2, 7, 0, 1, 0, 0, 0};
  localparam logic [15:0] V_X    [NV] = '{16'h0005, 16'h0010, 16'h0001, 16'h0002,
                                          16'h0005, 16'h0005, 16'h0001, 16'h0000,
                                          16'h00FF, 16'h0100, 16'h0000, 16'h4000,
                                          16'h3FFF, 16'h0000};
  localparam logic [15:0] V_Y    [NV] = '{16'h0003, 16'h0002, 16'h0001, 16'h0003,
                                          16'h0003, 16'h0003, 16'h0001, 16'h0000,
                                          16'h007F, 16'h0000, 16'h1000, 16'h0000,
                                          16'h0FFF, 16'h1000};
  localparam logic [31:0] V_ADDR [NV] = '{32'h0000C005, 32'h08010020, 32'h10008004,
                                          32'h18302000, 32'h67FF3FFA, 32'h8000A003,
                                          32'hB7FF8004, 32'h4FFF8000, 32'hF8000000,
                                          32'h00000000, 32'h00000000, 32'h00000000,
                                          32'h0FFFFFFE, 32'h00000000};
  localparam logic [31:0] V_STR  [NV] = '{32'h4000, 32'h8000, 32'h8000, 32'h100000,
                                          32'h4000, 32'h2000, 32'h4000, 32'h8000,
                                          32'h80000, 32'h100000, 32'h8000, 32'h4000,
                                          32'h8000, 32'h8000};
  localparam logic        V_OOR  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 1};

  task automatic check32(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check32({31'd0, out_valid}, 32'd0, "R11 valid in reset");
    check32(out_addr, 32'd0, "R11 addr in reset");
    check32(out_stride, 32'd0, "R11 stride in reset");
    rst = 1'b0;

    // Vector walk, one request per cycle (R1..R9)
    for (int v = 0; v < NV; v++) begin
      in_valid = 1'b1;
      in_fmt   = V_FMT[v];
      in_view  = V_VIEW[v];
      in_x     = V_X[v];
      in_y     = V_Y[v];
      @(negedge clk);
      check32({31'd0, out_valid}, 32'd1, "R9 valid after request");
      if (V_OOR[v])
        check32(out_addr, V_ADDR[v], $sformatf("R4 vector %0d", v));
      else
        check32(out_addr, V_ADDR[v], $sformatf("R1/R2/R3/R5/R6/R7 vector %0d", v));
      check32(out_stride, V_STR[v], $sformatf("R8 vector %0d", v));
    end

    // R10: inputs change without a request; results hold
    in_valid = 1'b1; in_fmt = 2'd0; in_view = 3'd3; in_x = 16'h0005; in_y = 16'h0003;
    @(negedge clk);
    check32(out_addr, 32'h67FF3FFA, "R5 reload");
    in_valid = 1'b0; in_fmt = 2'd3; in_view = 3'd4; in_x = 16'h0001; in_y = 16'h0001;
    repeat (3) @(negedge clk);
    check32({31'd0, out_valid}, 32'd0, "R9 valid low when idle");
    check32(out_addr, 32'h67FF3FFA, "R10 addr held");
    check32(out_stride, 32'h4000, "R10 stride held");

    // R3: page boundary, largest in-range Y, swap keeps Y width 7
    in_valid = 1'b1; in_fmt = 2'd3; in_view = 3'd4; in_x = 16'h0001; in_y = 16'h007F;
    @(negedge clk);
    check32(out_addr, 32'h98000000 | (((32'h1 << 7) + 32'h7F) << 12), "R3 page swap");
    check32(out_stride, 32'h80000, "R8 page swap");

    // R11: reset while a request is present
    rst = 1'b1;
    @(negedge clk);
    check32({31'd0, out_valid}, 32'd0, "R11 valid mid-run reset");
    check32(out_addr, 32'd0, "R11 addr mid-run reset");
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule